// File: doc/BRIEF.md
# Staged Channel-Interleave Address Dehasher

This block undoes the address hashing that a memory fabric applies when it spreads traffic across interleaved channels. A normalized physical address enters together with the interleave configuration: the bit position of the first interleave bit, the die and socket interleave counts, the channel count, and three enables that switch in hash terms at 64 KiB, 2 MiB and 1 GiB granularity. A generation select chooses between two fabric generations, each with its own legality rules and hash terms. The recovered address appears one clock later.

Recovery runs as a chain of stages, one per power of two of channels. Each stage takes the parity of its interleave bit and that stage's enabled hash bits. When the parity differs from the interleave bit, the stage inverts that bit. Every stage works on the address that the stages before it have already produced. When the configuration is illegal, the block raises an error flag and returns the address unmodified.

Top module: `chan_dehash`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `out_valid`, `out_addr` and `out_err` to zero.
- R2: `out_valid` equals `in_valid` from the previous rising edge. When `in_valid` is low, `out_addr` and `out_err` keep their values.
- R3: Generation select 0 is the older generation. Its first stage corrects the bit at position `in_ipos`. The hash for that stage is address bit 14 (always included), bit 18 when `in_h64k` is set, bit 23 when `in_h2m` is set, and bit 32 when `in_h1g` is set. A stage inverts its target bit exactly when the XOR of the enabled hash bits is 1.
- R4: In the older generation, a second stage corrects bit 12 from bits 16/21/30, and a third stage corrects bit 13 from bits 17/22/31. These terms are gated by the 64K/2M/1G enables in that order. With a channel count of 2 only the first stage runs. With 4 the first two stages run. With 8 all three run.
- R5: The older generation is illegal when `in_ipos` is not 8 or 9, when the die count exceeds 1, when the socket count exceeds 1, or when the channel count is not 2, 4 or 8. An illegal configuration sets `out_err` to 1 and returns the address unchanged.
- R6: Generation select 1 is the newer generation. Its first stage corrects bit 8 from bits 16/21/30, gated by 64K/2M/1G. Ungated bit 14 joins that hash only when the socket count is exactly 1.
- R7: In the newer generation, the total channel count decides how many stages run: at most 2 runs one stage, at most 4 runs two, at most 8 runs three, and more runs four. Stage two corrects bit 12 from bits 17/22/31. Stage three corrects bit 13 from bits 18/23/32. Stage four corrects bit 14 from bits 19/24/33. All of these use the same gating.
- R8: The newer generation is illegal when `in_ipos` is not 8, when the die count exceeds 1, when the socket count exceeds 2, or when the channel count is 0 or above 16. This gives the same error behaviour as R5.
- R9: Stages run in order, and each one reads the address as the earlier stages left it. In the newer generation, stage one therefore reads bit 14 before stage four corrects it.
- R10: Address bits other than 8, 9, 12, 13 and 14 always pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the inputs below |
| in_addr | input | AW (52) | Normalized, hashed physical address |
| in_gen | input | 1 | 0 = older generation, 1 = newer generation |
| in_ipos | input | PW (6) | Position of the first interleave bit |
| in_dies | input | CW (6) | Die interleave count |
| in_socks | input | CW (6) | Socket interleave count |
| in_chans | input | CW (6) | Channel count (total across sockets for the newer generation) |
| in_h64k | input | 1 | Enable for the 64 KiB hash terms |
| in_h2m | input | 1 | Enable for the 2 MiB hash terms |
| in_h1g | input | 1 | Enable for the 1 GiB hash terms |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_addr | output | AW (52) | Recovered address |
| out_err | output | 1 | Configuration was illegal |

## Verification
The bench builds the block with its default parameters: a 52-bit address and 6-bit position and count fields. At these widths every hash source up to bit 33 exists, and the top address bits can be used to show that untouched bits pass through. The 6-bit counts can hold values above every legal limit (17 channels, 3 sockets, 2 dies), so the illegal cases on both sides of each boundary can be reached. Directed vectors target each stage boundary and the chained stage-one/stage-four interaction. A randomized run covers the mixed configurations.

// File: rtl/dh_pkg.sv
package dh_pkg;
   typedef enum logic {
      GEN_OLD = 1'b0,
      GEN_NEW = 1'b1
   } dh_gen_e;

   localparam int unsigned NST = 4;

   // Hash sources per stage: {64K, 2M, 1G}
   localparam int unsigned HX_OLD [3][3] = '{'{18, 23, 32}, '{16, 21, 30}, '{17, 22, 31}};
   localparam int unsigned HX_NEW [4][3] = '{'{16, 21, 30}, '{17, 22, 31}, '{18, 23, 32}, '{19, 24, 33}};
   localparam int unsigned TG_OLD [3]    = '{8, 12, 13};
   localparam int unsigned TG_NEW [4]    = '{8, 12, 13, 14};
   localparam int unsigned FOLD_BIT      = 14;
   localparam int unsigned MIN_AW        = 34;
endpackage

// File: rtl/dh_stage.sv
module dh_stage #(
   parameter int unsigned AW = 52,
   parameter int unsigned PW = 6
) (
   input  logic [AW-1:0] a_in,
   input  logic [PW-1:0] tgt,
   input  logic [AW-1:0] mask,
   input  logic          act,
   output logic [AW-1:0] a_out
);
   logic flip;

   always_comb begin
      flip  = act & (^(a_in & mask));
      a_out = a_in;
      if (flip) a_out[tgt] = ~a_in[tgt];
   end

   // R3: a stage inverts at most one bit
   always_comb begin
      p_single_flip_r3: assert ($countones(a_in ^ a_out) <= 1)
         else $error("stage changed more than one bit");
   end
endmodule

// File: rtl/dh_plan.sv
module dh_plan
   import dh_pkg::*;
#(
   parameter int unsigned AW = 52,
   parameter int unsigned PW = 6,
   parameter int unsigned CW = 6
) (
   input  dh_gen_e       gen,
   input  logic [PW-1:0] ipos,
   input  logic [CW-1:0] dies,
   input  logic [CW-1:0] socks,
   input  logic [CW-1:0] chans,
   input  logic          h64k,
   input  logic          h2m,
   input  logic          h1g,
   output logic [PW-1:0] tgt  [NST],
   output logic [AW-1:0] mask [NST],
   output logic [NST-1:0] act,
   output logic          err
);
   function automatic logic [AW-1:0] bm(input int unsigned pos);
      logic [AW-1:0] m;
      m      = '0;
      m[pos] = 1'b1;
      return m;
   endfunction

   function automatic logic [AW-1:0] gated(input int unsigned p64, input int unsigned p2m,
                                          input int unsigned p1g);
      return (h64k ? bm(p64) : '0) | (h2m ? bm(p2m) : '0) | (h1g ? bm(p1g) : '0);
   endfunction

   always_comb begin
      for (int s = 0; s < NST; s++) begin
         tgt[s]  = '0;
         mask[s] = '0;
      end
      act = '0;
      err = 1'b0;
      unique case (gen)
         GEN_OLD: begin
            err = !(ipos == PW'(8) || ipos == PW'(9)) || dies > CW'(1) || socks > CW'(1) ||
                  !(chans == CW'(2) || chans == CW'(4) || chans == CW'(8));
            for (int s = 0; s < 3; s++) begin
               tgt[s]  = (s == 0) ? ipos : PW'(TG_OLD[s]);
               mask[s] = gated(HX_OLD[s][0], HX_OLD[s][1], HX_OLD[s][2]);
            end
            mask[0] = mask[0] | bm(FOLD_BIT);
            act[0]  = 1'b1;
            act[1]  = chans >= CW'(4);
            act[2]  = chans == CW'(8);
         end
         GEN_NEW: begin
            err = ipos != PW'(8) || dies > CW'(1) || socks > CW'(2) ||
                  chans == '0 || chans > CW'(16);
            for (int s = 0; s < 4; s++) begin
               tgt[s]  = PW'(TG_NEW[s]);
               mask[s] = gated(HX_NEW[s][0], HX_NEW[s][1], HX_NEW[s][2]);
            end
            if (socks == CW'(1)) mask[0] = mask[0] | bm(FOLD_BIT);
            act[0] = 1'b1;
            act[1] = chans > CW'(2);
            act[2] = chans > CW'(4);
            act[3] = chans > CW'(8);
         end
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/chan_dehash.sv
module chan_dehash
   import dh_pkg::*;
#(
   parameter int unsigned AW = 52,
   parameter int unsigned PW = $clog2(AW),
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [AW-1:0] in_addr,
   input  logic          in_gen,
   input  logic [PW-1:0] in_ipos,
   input  logic [CW-1:0] in_dies,
   input  logic [CW-1:0] in_socks,
   input  logic [CW-1:0] in_chans,
   input  logic          in_h64k,
   input  logic          in_h2m,
   input  logic          in_h1g,
   output logic          out_valid,
   output logic [AW-1:0] out_addr,
   output logic          out_err
);
   localparam logic [AW-1:0] TOUCH = AW'((1 << 8) | (1 << 9) | (1 << 12) | (1 << 13) | (1 << 14));

   generate
      if (AW < MIN_AW) begin : g_aw_chk
         $error("AW too small for the highest hash source bit");
      end
      if ((1 << PW) < AW) begin : g_pw_chk
         $error("PW cannot address every bit of AW");
      end
      if (CW < 5) begin : g_cw_chk
         $error("CW cannot hold a channel count of 16");
      end
   endgenerate

   logic [PW-1:0]  st_tgt  [NST];
   logic [AW-1:0]  st_mask [NST];
   logic [NST-1:0] st_act;
   logic           cfg_err;
   logic [AW-1:0]  chain [NST+1];
   logic [AW-1:0]  result;

   dh_plan #(.AW(AW), .PW(PW), .CW(CW)) u_plan (
      .gen   (dh_gen_e'(in_gen)),
      .ipos  (in_ipos),
      .dies  (in_dies),
      .socks (in_socks),
      .chans (in_chans),
      .h64k  (in_h64k),
      .h2m   (in_h2m),
      .h1g   (in_h1g),
      .tgt   (st_tgt),
      .mask  (st_mask),
      .act   (st_act),
      .err   (cfg_err)
   );

   assign chain[0] = in_addr;

   generate
      for (genvar s = 0; s < NST; s++) begin : g_stage
         dh_stage #(.AW(AW), .PW(PW)) u_st (
            .a_in  (chain[s]),
            .tgt   (st_tgt[s]),
            .mask  (st_mask[s]),
            .act   (st_act[s]),
            .a_out (chain[s+1])
         );
      end
   endgenerate

   assign result = cfg_err ? in_addr : chain[NST];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr <= result;
            out_err  <= cfg_err;
         end
      end
   end

   p_lat_r2: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid)
      else $error("valid not forwarded");
   p_idle_r2: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid)
      else $error("spurious valid");
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_addr) && $stable(out_err)))
      else $error("outputs moved while idle");
   p_keep_on_err_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cfg_err) |=> (out_err && out_addr == $past(in_addr)))
      else $error("illegal config altered address");
   p_touch_r10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (((out_addr ^ $past(in_addr)) & ~TOUCH) == '0))
      else $error("non-interleave bit changed");
   p_one_stage_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cfg_err && in_gen && in_chans <= CW'(2)) |=>
      (((out_addr ^ $past(in_addr)) & ~AW'(1 << 8)) == '0))
      else $error("extra stage ran for two channels");
endmodule

// File: tb/sim_chan_dehash.sv
`timescale 1ns/1ps
module sim_chan_dehash;
   localparam int AW = 52;
   localparam int PW = 6;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          in_gen = 1'b0;
   logic [PW-1:0] in_ipos = '0;
   logic [CW-1:0] in_dies = '0;
   logic [CW-1:0] in_socks = '0;
   logic [CW-1:0] in_chans = '0;
   logic          in_h64k = 1'b0;
   logic          in_h2m = 1'b0;
   logic          in_h1g = 1'b0;
   logic          out_valid;
   logic [AW-1:0] out_addr;
   logic          out_err;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_tag = "R2";

   chan_dehash #(.AW(AW), .PW(PW), .CW(CW)) u0 (.*);

   always #5 clk = ~clk;

   function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input bit gen, input int ipos,
         input int dies, input int socks, input int chans, input bit e64, input bit e2m,
         input bit e1g, output bit err);
      int tg[4]; int p64[4]; int p2[4]; int p1[4]; int n; bit h;
      if (!gen) begin
         err = !(ipos == 8 || ipos == 9) || dies > 1 || socks > 1 ||
               !(chans == 2 || chans == 4 || chans == 8);
         tg = '{ipos, 12, 13, 0}; p64 = '{18, 16, 17, 0}; p2 = '{23, 21, 22, 0}; p1 = '{32, 30, 31, 0};
         n = (chans == 2) ? 1 : (chans == 4) ? 2 : 3;
      end else begin
         err = ipos != 8 || dies > 1 || socks > 2 || chans == 0 || chans > 16;
         tg = '{8, 12, 13, 14}; p64 = '{16, 17, 18, 19}; p2 = '{21, 22, 23, 24}; p1 = '{30, 31, 32, 33};
         n = (chans <= 2) ? 1 : (chans <= 4) ? 2 : (chans <= 8) ? 3 : 4;
      end
      if (err) return a;
      for (int s = 0; s < n; s++) begin
         h = a[tg[s]];
         if (e64) h ^= a[p64[s]];
         if (e2m) h ^= a[p2[s]];
         if (e1g) h ^= a[p1[s]];
         if (s == 0 && (!gen || socks == 1)) h ^= a[14];
         if (h != a[tg[s]]) a[tg[s]] = ~a[tg[s]];
      end
      return a;
   endfunction

   // Reference pipeline, advanced on every rising edge
   logic          m_valid = 1'b0;
   logic [AW-1:0] m_addr = '0;
   bit            m_err = 0;
   string         m_tag = "R2";
   bit            armed = 0;

   always @(posedge clk) begin
      bit e;
      logic [AW-1:0] r;
      if (rst) begin
         m_valid <= 1'b0; m_addr <= '0; m_err <= 0;
      end else begin
         m_valid <= in_valid;
         m_tag   <= cur_tag;
         if (in_valid) begin
            r = model(in_addr, in_gen, int'(in_ipos), int'(in_dies), int'(in_socks),
                      int'(in_chans), in_h64k, in_h2m, in_h1g, e);
            m_addr <= r;
            m_err  <= e;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst && armed && !done) begin
         total++;
         if (out_valid !== m_valid || out_addr !== m_addr || out_err !== m_err) begin
            bad++;
            $display("FAIL %s model: got v=%0b a=%h e=%0b exp v=%0b a=%h e=%0b", m_tag,
                     out_valid, out_addr, out_err, m_valid, m_addr, m_err);
         end
      end
   end

   function automatic logic [AW-1:0] b(input int p);
      logic [AW-1:0] m;
      m = '0; m[p] = 1'b1;
      return m;
   endfunction

   task automatic send(input string tag, input logic [AW-1:0] a, input bit gen, input int ipos,
         input int dies, input int socks, input int chans, input bit e64, input bit e2m,
         input bit e1g, input bit chk, input logic [AW-1:0] ea, input bit ee);
      @(negedge clk);
      cur_tag = tag;
      in_addr = a; in_gen = gen; in_ipos = PW'(ipos); in_dies = CW'(dies);
      in_socks = CW'(socks); in_chans = CW'(chans);
      in_h64k = e64; in_h2m = e2m; in_h1g = e1g; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (chk) begin
         total++;
         if (out_valid !== 1'b1 || out_addr !== ea || out_err !== ee) begin
            bad++;
            $display("FAIL %s: got v=%0b a=%h e=%0b exp v=1 a=%h e=%0b", tag,
                     out_valid, out_addr, out_err, ea, ee);
         end
      end
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      total++; // R1: reset state
      if (out_valid !== 1'b0 || out_addr !== '0 || out_err !== 1'b0) begin
         bad++;
         $display("FAIL R1: got v=%0b a=%h e=%0b exp v=0 a=0 e=0", out_valid, out_addr, out_err);
      end
      rst = 1'b0;
      armed = 1;
      // R3: older stage one
      send("R3", b(14), 0, 8, 0, 0, 2, 0, 0, 0, 1, b(14) | b(8), 0);
      send("R3", b(18), 0, 9, 1, 1, 2, 1, 0, 0, 1, b(18) | b(9), 0);
      send("R3", b(18), 0, 9, 1, 1, 2, 0, 0, 0, 1, b(18), 0);
      send("R3", b(23) | b(32), 0, 8, 0, 0, 2, 0, 1, 0, 1, b(23) | b(32) | b(8), 0);
      // R4: older stages two and three
      send("R4", b(16) | b(30), 0, 8, 0, 0, 4, 1, 0, 1, 1, b(16) | b(30), 0);
      send("R4", b(21), 0, 8, 0, 0, 4, 0, 1, 0, 1, b(21) | b(12), 0);
      send("R4", b(21), 0, 8, 0, 0, 2, 0, 1, 0, 1, b(21), 0);
      send("R4", b(31), 0, 8, 0, 0, 8, 0, 0, 1, 1, b(31) | b(13), 0);
      send("R4", b(31), 0, 8, 0, 0, 4, 0, 0, 1, 1, b(31), 0);
      // R5: older legality
      send("R5", b(14), 0, 10, 0, 0, 2, 0, 0, 0, 1, b(14), 1);
      send("R5", b(14), 0, 8, 2, 0, 2, 0, 0, 0, 1, b(14), 1);
      send("R5", b(14), 0, 8, 0, 2, 2, 0, 0, 0, 1, b(14), 1);
      send("R5", b(14), 0, 8, 0, 0, 3, 0, 0, 0, 1, b(14), 1);
      // R6: newer stage one
      send("R6", b(14), 1, 8, 0, 1, 2, 0, 0, 0, 1, b(14) | b(8), 0);
      send("R6", b(14), 1, 8, 0, 2, 2, 0, 0, 0, 1, b(14), 0);
      send("R6", b(16), 1, 8, 1, 2, 2, 1, 0, 0, 1, b(16) | b(8), 0);
      // R7: newer stage count
      send("R7", b(17), 1, 8, 0, 2, 3, 1, 0, 0, 1, b(17) | b(12), 0);
      send("R7", b(17), 1, 8, 0, 2, 2, 1, 0, 0, 1, b(17), 0);
      send("R7", b(23), 1, 8, 0, 2, 8, 0, 1, 0, 1, b(23) | b(13), 0);
      send("R7", b(23), 1, 8, 0, 2, 4, 0, 1, 0, 1, b(23), 0);
      send("R7", b(33), 1, 8, 0, 2, 16, 0, 0, 1, 1, b(33) | b(14), 0);
      send("R7", b(33), 1, 8, 0, 2, 8, 0, 0, 1, 1, b(33), 0);
      // R8: newer legality
      send("R8", b(16), 1, 9, 0, 0, 2, 1, 0, 0, 1, b(16), 1);
      send("R8", b(16), 1, 8, 2, 0, 2, 1, 0, 0, 1, b(16), 1);
      send("R8", b(16), 1, 8, 0, 3, 2, 1, 0, 0, 1, b(16), 1);
      send("R8", b(16), 1, 8, 0, 0, 0, 1, 0, 0, 1, b(16), 1);
      send("R8", b(16), 1, 8, 0, 0, 17, 1, 0, 0, 1, b(16), 1);
      // R9: stage one reads bit 14 before stage four changes it
      send("R9", b(14) | b(19), 1, 8, 0, 1, 16, 1, 0, 0, 1, b(8) | b(19), 0);
      // R10: untouched bits pass through
      send("R10", b(51) | b(45) | b(7) | b(0), 0, 8, 0, 0, 8, 1, 1, 1, 1,
           b(51) | b(45) | b(7) | b(0), 0);
      repeat (2) @(negedge clk); // R2: hold while idle, checked by the model compare
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         int ch, ip;
         bit g;
         a  = AW'({$urandom, $urandom});
         g  = $urandom_range(0, 1);
         ip = ($urandom_range(0, 7) == 0) ? 10 : $urandom_range(8, 9);
         case ($urandom_range(0, 6))
            0: ch = 1; 1: ch = 2; 2: ch = 3; 3: ch = 4;
            4: ch = 8; 5: ch = 16; default: ch = $urandom_range(0, 20);
         endcase
         send("R10", a, g, ip, $urandom_range(0, 1), $urandom_range(0, 2), ch,
              $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), 0, '0, 0);
         if ($urandom_range(0, 3) == 0) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule